// File: doc/BRIEF.md
# Watchdog Timer with Two-Key Clear

This block is a watchdog counter for a small processor core. An 8-bit counter advances by one on every cycle in which the external tick enable is high. When it wraps from its maximum value back to zero, the block latches a time-out status bit and issues a one-cycle reset pulse to the rest of the chip. Software keeps the watchdog from firing by clearing it. The instruction decoder turns the clear instructions into single-cycle command strobes on this block's inputs.

Two clear schemes are available, and a static mode input picks one. In single mode, one clear strobe zeroes the counter and both status bits. In paired mode, two distinct preclear strobes (key A and key B) are needed, in either order. The first strobe only raises its own pending flag. The clear takes effect when the second, different key arrives, and both pending flags then drop. A sleep request raises the power-down status bit, and only a clear lowers it again. The two status bits also appear at their fixed positions in an 8-bit status byte slice, which the core merges with its arithmetic flags.

Top module: `wdog_dual_key`

## Requirements
- R1: A synchronous active-high reset sets the counter, time-out bit, power-down bit, both pending flags and the reset pulse to 0.
- R2: With no clear taking effect, the counter increases by one in the cycle after each cycle in which tick is high, and holds otherwise.
- R3: A tick while the counter is 0xFF, with no clear taking effect, sets the counter to 0x00 and the time-out bit to 1, and the reset pulse output is high for exactly the cycle after that tick.
- R4: In single mode (mode_paired = 0), a clear strobe zeroes the counter, the time-out bit and the power-down bit on the next cycle.
- R5: In single mode the preclear strobes have no effect: the pending flags stay 0 and the counter and status bits behave as if they were low.
- R6: In paired mode (mode_paired = 1), a preclear strobe whose partner is not pending and not strobed sets only its own pending flag. The counter, time-out and power-down bits are unaffected.
- R7: In paired mode, a preclear strobe whose partner is pending, or both strobes in the same cycle, zero the counter, time-out and power-down bits and both pending flags on the next cycle.
- R8: Repeating the same preclear strobe while its partner is absent has no additional effect. The clear still waits for the other key.
- R9: In paired mode the single clear strobe has no effect.
- R10: A sleep request sets the power-down bit to 1. Only a clear that takes effect (R4 or R7) returns it to 0.
- R11: A clear that takes effect in the same cycle as a tick or a sleep request wins: the counter becomes 0 and the power-down bit becomes 0.
- R12: The status slice carries the time-out bit at bit 5 and the power-down bit at bit 4. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_paired | input | 1 | Static scheme select: 1 = two-key clear, 0 = single clear |
| tick | input | 1 | Counter advance enable |
| cmd_clr | input | 1 | Single clear strobe |
| cmd_key_a | input | 1 | Preclear key A strobe |
| cmd_key_b | input | 1 | Preclear key B strobe |
| sleep_req | input | 1 | Sleep request, sets power-down |
| count | output | 8 | Current watchdog count |
| time_out | output | 1 | Time-out status bit |
| power_down | output | 1 | Power-down status bit |
| key_a_pend | output | 1 | Key A seen, waiting for key B |
| key_b_pend | output | 1 | Key B seen, waiting for key A |
| wdt_reset | output | 1 | One-cycle reset pulse on wrap |
| stat_slice | output | 8 | Status byte slice with the watchdog bits in place |

## Verification
A lost or stuck pending flag shows up at the ports one cycle after the strobe, both on the pending outputs and in whether the count returns to zero when the partner key arrives. A counter that misses a step or wraps at the wrong point drifts from the bench's count on the next tick. A wrong wrap threshold also moves the reset pulse by up to 256 ticks. Priority faults between clear, tick and sleep show up in the one cycle where they collide, as a nonzero count or a power-down bit left set.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned CNT_W     = 8;
  localparam int unsigned NUM_KEYS  = 2;
  localparam int unsigned STAT_W    = 8;
  localparam int unsigned TO_POS    = 5;
  localparam int unsigned PD_POS    = 4;

  typedef logic [CNT_W-1:0] wd_count_t;
endpackage

// File: rtl/wdog_key_ctrl.sv
module wdog_key_ctrl #(
  parameter int unsigned NKEYS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_paired,
  input  logic             cmd_clr,
  input  logic [NKEYS-1:0] key_strobe,
  output logic [NKEYS-1:0] key_pend,
  output logic             clr_now
);
  logic [NKEYS-1:0] key_hit;
  logic             pair_done;

  genvar k;
  generate
    for (k = 0; k < NKEYS; k++) begin : g_key
      assign key_hit[k] = key_pend[k] | key_strobe[k];

      always_ff @(posedge clk) begin
        if (rst) begin
          key_pend[k] <= 1'b0;
        end else if (mode_paired) begin
          if (pair_done) key_pend[k] <= 1'b0;
          else if (key_strobe[k]) key_pend[k] <= 1'b1;
        end
      end

      // R6: a pending key stays pending until the pair completes (or reset)
      a_r6_pend_sticky: assert property (@(posedge clk) disable iff (rst)
        (key_pend[k] && !pair_done) |=> key_pend[k]);
      // R5: in single mode a pending flag never rises
      a_r5_no_pend_single: assert property (@(posedge clk) disable iff (rst)
        (!mode_paired && !key_pend[k]) |=> !key_pend[k]);
    end
  endgenerate

  assign pair_done = (&key_hit) & (|key_strobe);
  assign clr_now   = mode_paired ? pair_done : cmd_clr;

  // R7: a completed pair leaves no key pending
  a_r7_pend_drop: assert property (@(posedge clk) disable iff (rst)
    (mode_paired && pair_done) |=> (key_pend == '0));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] count_q,
  output logic         wrap
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  assign wrap = tick & ~clr & (count_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst || clr) count_q <= '0;
    else if (tick) count_q <= count_q + 1'b1;
  end

  // R2: one step per tick when no clear
  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr) |=> (count_q == $past(count_q) + 1'b1));
  // R11: clear always wins over tick
  a_r11_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count_q == '0));
endmodule

// File: rtl/wdog_flags.sv
module wdog_flags (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic wrap,
  input  logic sleep_req,
  output logic to_q,
  output logic pd_q,
  output logic pulse_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      to_q    <= 1'b0;
      pd_q    <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= wrap;
      if (clr) to_q <= 1'b0;
      else if (wrap) to_q <= 1'b1;
      if (clr) pd_q <= 1'b0;
      else if (sleep_req) pd_q <= 1'b1;
    end
  end

  // R3: wrap latches time-out
  a_r3_wrap_sets_to: assert property (@(posedge clk) disable iff (rst)
    wrap |=> to_q);
  // R3: reset pulse lasts one cycle
  a_r3_pulse_single: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q);
  // R10: power-down falls only after a clear
  a_r10_pd_lowered_by_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(pd_q) |-> $past(clr));
endmodule

// File: rtl/wdog_dual_key.sv
module wdog_dual_key
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_paired,
  input  logic              tick,
  input  logic              cmd_clr,
  input  logic              cmd_key_a,
  input  logic              cmd_key_b,
  input  logic              sleep_req,
  output logic [CNT_W-1:0]  count,
  output logic              time_out,
  output logic              power_down,
  output logic              key_a_pend,
  output logic              key_b_pend,
  output logic              wdt_reset,
  output logic [STAT_W-1:0] stat_slice
);
  logic [NUM_KEYS-1:0] strobes;
  logic [NUM_KEYS-1:0] pend;
  logic                clr_now;
  logic                wrap;

  assign strobes = {cmd_key_b, cmd_key_a};

  wdog_key_ctrl #(.NKEYS(NUM_KEYS)) u_keys (
    .clk(clk), .rst(rst), .mode_paired(mode_paired), .cmd_clr(cmd_clr),
    .key_strobe(strobes), .key_pend(pend), .clr_now(clr_now)
  );

  wdog_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(clr_now), .tick(tick),
    .count_q(count), .wrap(wrap)
  );

  wdog_flags u_flags (
    .clk(clk), .rst(rst), .clr(clr_now), .wrap(wrap), .sleep_req(sleep_req),
    .to_q(time_out), .pd_q(power_down), .pulse_q(wdt_reset)
  );

  assign key_a_pend = pend[0];
  assign key_b_pend = pend[1];

  always_comb begin
    stat_slice         = '0;
    stat_slice[TO_POS] = time_out;
    stat_slice[PD_POS] = power_down;
  end

  // R9: in paired mode a lone clear strobe with no key leaves the count running
  a_r9_clr_ignored: assert property (@(posedge clk) disable iff (rst)
    (mode_paired && cmd_clr && !cmd_key_a && !cmd_key_b && tick && count != '1)
      |=> (count == $past(count) + 1'b1));
endmodule

// File: tb/test_wdog_dual_key.sv
`timescale 1ns/1ps
module test_wdog_dual_key;
  logic clk = 1'b0;
  logic rst, mode_paired, tick, cmd_clr, cmd_key_a, cmd_key_b, sleep_req;
  logic [7:0] count, stat_slice;
  logic time_out, power_down, key_a_pend, key_b_pend, wdt_reset;

  int checks = 0;
  int errors = 0;
  int m_cnt, m_to, m_pd, m_pa, m_pb, m_rst;

  always #2.5 clk = ~clk;

  wdog_dual_key i_wdog_dual_key (
    .clk(clk), .rst(rst), .mode_paired(mode_paired), .tick(tick),
    .cmd_clr(cmd_clr), .cmd_key_a(cmd_key_a), .cmd_key_b(cmd_key_b),
    .sleep_req(sleep_req), .count(count), .time_out(time_out),
    .power_down(power_down), .key_a_pend(key_a_pend), .key_b_pend(key_b_pend),
    .wdt_reset(wdt_reset), .stat_slice(stat_slice)
  );

  task automatic chk(string req, string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (%s) actual=%0d expected=%0d at %0t", req, tag, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    chk("R2", tag, int'(count), m_cnt);
    chk("R3", tag, int'(time_out), m_to);
    chk("R3", tag, int'(wdt_reset), m_rst);
    chk("R10", tag, int'(power_down), m_pd);
    chk("R6", tag, int'(key_a_pend), m_pa);
    chk("R6", tag, int'(key_b_pend), m_pb);
    chk("R12", tag, int'(stat_slice), (m_to << 5) | (m_pd << 4));
  endtask

  task automatic step(string tag, bit tk, bit cl, bit ka, bit kb, bit sl);
    bit clr_now, ovf;
    tick = tk; cmd_clr = cl; cmd_key_a = ka; cmd_key_b = kb; sleep_req = sl;
    if (mode_paired) clr_now = (ka || m_pa) && (kb || m_pb) && (ka || kb);
    else clr_now = cl;
    ovf = !clr_now && tk && (m_cnt == 255);
    if (mode_paired) begin
      if (clr_now) begin m_pa = 0; m_pb = 0; end
      else begin
        if (ka) m_pa = 1;
        if (kb) m_pb = 1;
      end
    end
    if (clr_now) m_cnt = 0;
    else if (tk) m_cnt = (m_cnt + 1) % 256;
    if (clr_now) m_to = 0; else if (ovf) m_to = 1;
    if (clr_now) m_pd = 0; else if (sl) m_pd = 1;
    m_rst = ovf;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; mode_paired = 1'b0; tick = 1'b1; cmd_clr = 1'b0;
    cmd_key_a = 1'b1; cmd_key_b = 1'b0; sleep_req = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    m_cnt = 0; m_to = 0; m_pd = 0; m_pa = 0; m_pb = 0; m_rst = 0;
    compare("R1 reset");
    rst = 1'b0;

    // single mode
    for (int i = 0; i < 10; i++) step("R2 ticks", 1, 0, 0, 0, 0);
    step("R2 hold", 0, 0, 0, 0, 0);
    step("R10 sleep", 1, 0, 0, 0, 1);
    step("R10 pd held", 1, 0, 0, 0, 0);
    step("R4 single clear", 0, 1, 0, 0, 0);
    chk("R4", "count zero", int'(count), 0);
    for (int i = 0; i < 4; i++) step("R2 ticks", 1, 0, 0, 0, 0);
    step("R5 key a ignored", 1, 0, 1, 0, 0);
    step("R5 key b ignored", 1, 0, 0, 1, 0);
    step("R5 both ignored", 1, 0, 1, 1, 0);
    chk("R5", "count kept", int'(count), 7);
    for (int i = 0; i < 260; i++) step("R3 run to wrap", 1, 0, 0, 0, 0);
    chk("R3", "time-out latched", int'(time_out), 1);
    step("R10 sleep", 0, 0, 0, 0, 1);
    step("R4 clear to/pd", 0, 1, 0, 0, 0);
    chk("R4", "time-out cleared", int'(time_out), 0);
    step("R2 tick", 1, 0, 0, 0, 0);
    step("R11 clear beats tick+sleep", 1, 1, 0, 0, 1);
    chk("R11", "pd zero", int'(power_down), 0);

    // paired mode
    mode_paired = 1'b1;
    for (int i = 0; i < 3; i++) step("R2 ticks", 1, 0, 0, 0, 0);
    step("R9 clear ignored", 1, 1, 0, 0, 0);
    chk("R9", "count kept", int'(count), 4);
    step("R10 sleep", 1, 0, 0, 0, 1);
    step("R6 key a", 1, 0, 1, 0, 0);
    chk("R6", "pd unchanged", int'(power_down), 1);
    step("R8 key a again", 1, 0, 1, 0, 0);
    step("R8 key a third", 1, 0, 1, 0, 0);
    chk("R8", "no clear", int'(count), 8);
    step("R7 key b completes", 1, 0, 0, 1, 0);
    chk("R7", "count zero", int'(count), 0);
    for (int i = 0; i < 5; i++) step("R2 ticks", 1, 0, 0, 0, 0);
    step("R6 key b first", 1, 0, 0, 1, 0);
    step("R8 key b again", 0, 0, 0, 1, 0);
    step("R9 clear ignored", 1, 1, 0, 0, 0);
    step("R7 key a completes", 1, 0, 1, 0, 1);
    chk("R7", "pend cleared", int'(key_b_pend), 0);
    for (int i = 0; i < 258; i++) step("R3 paired wrap", 1, 0, 0, 0, 0);
    step("R10 sleep", 1, 0, 0, 0, 1);
    step("R7 both keys same cycle", 1, 0, 1, 1, 0);
    chk("R7", "time-out cleared", int'(time_out), 0);
    step("R2 tick", 1, 0, 0, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule